// File: doc/BRIEF.md
# Instruction page escape controller

This block keeps track of which alternate opcode subpage a processor's instruction decoder should use. A small stack holds page activations. Each entry pairs a 3-bit subpage number with a 4-bit length. The length is either a count of instructions or a code meaning "permanent". While the stack is empty, the decoder runs the default base instruction set.

The retire stage reports every retiring instruction to the block. It also reports whether that instruction was a taken branch and whether it was a page-control command: select-and-push, pop-one or return-to-default. Ordinary retirements count down the top activation, and the activation lapses by itself when its count runs out. A taken branch ends a counted activation at once. All of the state packs into one 31-bit CSR, so software can save it and restore it around calls and context switches.

Top module: `page_escape_ctrl`

## Requirements
- R1: After reset, `base_o` is 1, `page_o` is 0 and `csr_rdata_o` is 0.
- R2: A push command (`cmd_i` = 2'b01) with a length of 1..15 makes `sel_page_i` the active page on the next cycle and raises the depth by one. A push with length 0 has no effect.
- R3: A top entry with length L in 1..14 stays active for exactly L ordinary retirements (`retire_i`=1, `cmd_i`=2'b00, `branch_i`=0). After the L-th one it is popped and the entry below becomes active. Page-control commands do not count, and neither do cycles with `retire_i`=0.
- R4: Length 15 is permanent: ordinary retirements and taken branches leave that entry unchanged.
- R5: A taken branch (`retire_i`=1 and `branch_i`=1) pops a counted top entry. Only the top entry is removed.
- R6: A pop command (`cmd_i` = 2'b10) removes exactly one entry.
- R7: A return-to-default command (`cmd_i` = 2'b11) empties the stack: depth 0, all entry bits 0, `base_o`=1.
- R8: A push while the stack holds 4 entries overwrites the top entry, and the depth stays at 4.
- R9: A pop, an expiry or a branch at depth 0 has no effect: `base_o` stays 1 and `page_o` stays 0.
- R10: The CSR layout is as follows. The depth sits in bits [30:28]. Entry i (0 = bottom) sits in bits [7i+6:7i], with its page in [7i+6:7i+4] and its length in [7i+3:7i]. `page_o` is the page of entry depth-1, or 0 when the depth is 0.
- R11: A CSR write (`csr_we_i`) replaces the whole state on the next cycle. It overrides any command, retirement or branch in the same cycle. A written depth above 4 is stored as 4.
- R12: An entry removed by a pop, an expiry or a branch reads back as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | An instruction retires this cycle |
| branch_i | input | 1 | The retiring instruction is a taken branch |
| cmd_i | input | 2 | Page command: 00 none, 01 push, 10 pop, 11 return to default |
| sel_page_i | input | 3 | Subpage number carried by a push |
| sel_len_i | input | 4 | Activation length carried by a push (15 = permanent) |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 31 | CSR write data |
| csr_rdata_o | output | 31 | Packed state |
| page_o | output | 3 | Active subpage number |
| base_o | output | 1 | Default base instruction set is active |

## Verification
The bench interleaves push commands with ordinary retirements, to catch a design that lets a command decrement the count. Such a design would pop a page one instruction early. Taken branches are applied under both a counted top and a permanent top. A design that got this wrong would either drop a permanent page or pop entries below the top. The bench also pushes onto a full stack, pops on an empty one, and writes an out-of-range depth. Errors there show up as depth wraparound or a stray active page. A CSR write issued together with a pop checks that the write wins.

// File: rtl/pge_pkg.sv
package pge_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_PUSH  = 2'b01,
    CMD_POP   = 2'b10,
    CMD_CLEAR = 2'b11
  } pge_cmd_e;
endpackage

// File: rtl/pge_countdown.sv
module pge_countdown #(
  parameter int LEN_W = 4
) (
  input  logic             valid_i,
  input  logic [LEN_W-1:0] top_len_i,
  input  logic             retire_i,
  input  logic             branch_i,
  output logic             expire_o,
  output logic             dec_o,
  output logic [LEN_W-1:0] next_len_o
);
  localparam logic [LEN_W-1:0] PERM = '1;
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

  logic perm;
  logic live;

  assign perm       = (top_len_i == PERM);
  assign live       = valid_i & retire_i & ~perm;
  assign expire_o   = live & (branch_i | (top_len_i <= ONE));
  assign dec_o      = live & ~branch_i & (top_len_i > ONE);
  assign next_len_o = top_len_i - ONE;
endmodule

// File: rtl/pge_stack.sv
module pge_stack #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4,
  localparam int ENT_W   = PAGE_W + LEN_W,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [DEPTH-1:0][ENT_W-1:0] load_ents_i,
  input  logic [DEPTH_W-1:0]          load_depth_i,
  input  logic                        clear_i,
  input  logic                        push_i,
  input  logic [ENT_W-1:0]            push_ent_i,
  input  logic                        pop_i,
  input  logic                        dec_i,
  input  logic [LEN_W-1:0]            dec_len_i,
  output logic [DEPTH-1:0][ENT_W-1:0] ents_o,
  output logic [DEPTH_W-1:0]          depth_o,
  output logic [ENT_W-1:0]            top_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  logic [DEPTH-1:0][ENT_W-1:0] ents_q;
  logic [DEPTH_W-1:0]          depth_q;
  logic                        full;
  logic                        empty;
  logic [DEPTH_W-1:0]          top_idx;

  assign full    = (depth_q == FULL);
  assign empty   = (depth_q == '0);
  assign top_idx = depth_q - DEPTH_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [DEPTH_W-1:0] IDX = DEPTH_W'(i);
    logic is_top;
    logic push_here;
    assign is_top    = !empty && (top_idx == IDX);
    assign push_here = full ? (IDX == FULL - DEPTH_W'(1)) : (depth_q == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 ents_q[i] <= '0;
      else if (load_i)             ents_q[i] <= load_ents_i[i];
      else if (clear_i)            ents_q[i] <= '0;
      else if (push_i)             begin if (push_here) ents_q[i] <= push_ent_i; end
      else if (pop_i && is_top)    ents_q[i] <= '0;
      else if (dec_i && is_top)    ents_q[i][LEN_W-1:0] <= dec_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                depth_q <= '0;
    else if (load_i)            depth_q <= load_depth_i;
    else if (clear_i)           depth_q <= '0;
    else if (push_i)            begin if (!full) depth_q <= depth_q + DEPTH_W'(1); end
    else if (pop_i && !empty)   depth_q <= top_idx;
  end

  always_comb begin
    top_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (!empty && top_idx == DEPTH_W'(k)) top_o = ents_q[k];
  end

  assign ents_o  = ents_q;
  assign depth_o = depth_q;

  always_comb a_r11_depth_bound: assert (!rst_ni || depth_q <= FULL);
endmodule

// File: rtl/pge_csr_map.sv
module pge_csr_map #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4,
  localparam int ENT_W   = PAGE_W + LEN_W,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int CSR_W   = DEPTH * ENT_W + DEPTH_W
) (
  input  logic [DEPTH-1:0][ENT_W-1:0] ents_i,
  input  logic [DEPTH_W-1:0]          depth_i,
  input  logic [CSR_W-1:0]            wdata_i,
  output logic [CSR_W-1:0]            rdata_o,
  output logic [DEPTH-1:0][ENT_W-1:0] w_ents_o,
  output logic [DEPTH_W-1:0]          w_depth_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  logic [DEPTH_W-1:0] raw_depth;

  assign rdata_o   = {depth_i, ents_i};
  assign w_ents_o  = wdata_i[DEPTH*ENT_W-1:0];
  assign raw_depth = wdata_i[CSR_W-1 -: DEPTH_W];
  // out-of-range depth clamps to a full stack
  assign w_depth_o = (raw_depth > FULL) ? FULL : raw_depth;
endmodule

// File: rtl/page_escape_ctrl.sv
module page_escape_ctrl #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4,
  localparam int ENT_W   = PAGE_W + LEN_W,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int CSR_W   = DEPTH * ENT_W + DEPTH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              branch_i,
  input  logic [1:0]        cmd_i,
  input  logic [PAGE_W-1:0] sel_page_i,
  input  logic [LEN_W-1:0]  sel_len_i,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              base_o
);
  import pge_pkg::*;

  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  pge_cmd_e                    cmd;
  logic [DEPTH-1:0][ENT_W-1:0] ents;
  logic [DEPTH_W-1:0]          depth;
  logic [ENT_W-1:0]            top;
  logic [DEPTH-1:0][ENT_W-1:0] w_ents;
  logic [DEPTH_W-1:0]          w_depth;
  logic                        expire, dec;
  logic [LEN_W-1:0]            next_len;
  logic                        plain;
  logic                        do_push, do_pop, do_clear;

  assign cmd      = pge_cmd_e'(cmd_i);
  assign plain    = (cmd == CMD_NONE);
  assign do_push  = (cmd == CMD_PUSH) && (sel_len_i != '0);
  assign do_clear = (cmd == CMD_CLEAR);
  assign do_pop   = (cmd == CMD_POP) || (plain && expire);

  pge_countdown #(.LEN_W(LEN_W)) u_cd (
    .valid_i    (depth != '0),
    .top_len_i  (top[LEN_W-1:0]),
    .retire_i   (retire_i),
    .branch_i   (branch_i),
    .expire_o   (expire),
    .dec_o      (dec),
    .next_len_o (next_len)
  );

  pge_stack #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_stack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (csr_we_i),
    .load_ents_i  (w_ents),
    .load_depth_i (w_depth),
    .clear_i      (do_clear),
    .push_i       (do_push),
    .push_ent_i   ({sel_page_i, sel_len_i}),
    .pop_i        (do_pop),
    .dec_i        (plain && dec),
    .dec_len_i    (next_len),
    .ents_o       (ents),
    .depth_o      (depth),
    .top_o        (top)
  );

  pge_csr_map #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_map (
    .ents_i    (ents),
    .depth_i   (depth),
    .wdata_i   (csr_wdata_i),
    .rdata_o   (csr_rdata_o),
    .w_ents_o  (w_ents),
    .w_depth_o (w_depth)
  );

  assign page_o = top[ENT_W-1:LEN_W];
  assign base_o = (depth == '0);

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && do_push && depth < FULL) |=>
      (csr_rdata_o[CSR_W-1 -: DEPTH_W] == $past(depth) + DEPTH_W'(1)) && (page_o == $past(sel_page_i)));
  a_r8_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && do_push && depth == FULL) |=> csr_rdata_o[CSR_W-1 -: DEPTH_W] == FULL);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && do_clear) |=> base_o && csr_rdata_o == '0);
  a_r9_empty_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !do_push && base_o) |=> base_o && page_o == '0);
  a_r4_perm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && plain && !base_o && top[LEN_W-1:0] == '1) |=> $stable(csr_rdata_o));
  a_r11_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[CSR_W-1 -: DEPTH_W] <= FULL) |=> csr_rdata_o == $past(csr_wdata_i));
endmodule

// File: tb/page_escape_ctrl_bench.sv
`timescale 1ns/1ps
module page_escape_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire, branch, we;
  logic [1:0]  cmd;
  logic [2:0]  pg;
  logic [3:0]  ln;
  logic [30:0] wdata, rdata;
  logic [2:0]  page;
  logic        base;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  page_escape_ctrl u_page_escape_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .branch_i(branch),
    .cmd_i(cmd), .sel_page_i(pg), .sel_len_i(ln), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .page_o(page), .base_o(base));

  typedef struct packed {
    logic [1:0] c; logic [2:0] p; logic [3:0] l; logic r; logic b;
    logic [2:0] xp; logic xb; logic [2:0] xd;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd1,3'd3,4'd2, 1'b1,1'b0, 3'd3,1'b0,3'd1}, // R2
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd3,1'b0,3'd1}, // R3
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd0,1'b1,3'd0}, // R3 expiry
    '{2'd1,3'd5,4'd15,1'b1,1'b0, 3'd5,1'b0,3'd1}, // R4
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd5,1'b0,3'd1}, // R4
    '{2'd1,3'd2,4'd3, 1'b1,1'b0, 3'd2,1'b0,3'd2}, // R2
    '{2'd1,3'd6,4'd0, 1'b1,1'b0, 3'd2,1'b0,3'd2}, // R2 len 0
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd2,1'b0,3'd2}, // R3
    '{2'd1,3'd1,4'd1, 1'b1,1'b0, 3'd1,1'b0,3'd3}, // R3 cmd no count
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd2,1'b0,3'd2}, // R3
    '{2'd0,3'd0,4'd0, 1'b1,1'b1, 3'd5,1'b0,3'd1}, // R5
    '{2'd0,3'd0,4'd0, 1'b1,1'b1, 3'd5,1'b0,3'd1}, // R4 branch
    '{2'd2,3'd0,4'd0, 1'b1,1'b0, 3'd0,1'b1,3'd0}, // R6
    '{2'd2,3'd0,4'd0, 1'b1,1'b0, 3'd0,1'b1,3'd0}, // R9
    '{2'd0,3'd0,4'd0, 1'b1,1'b1, 3'd0,1'b1,3'd0}, // R9
    '{2'd1,3'd7,4'd4, 1'b1,1'b0, 3'd7,1'b0,3'd1}, // R2
    '{2'd3,3'd0,4'd0, 1'b1,1'b0, 3'd0,1'b1,3'd0}, // R7
    '{2'd1,3'd4,4'd2, 1'b1,1'b0, 3'd4,1'b0,3'd1}, // R2
    '{2'd0,3'd0,4'd0, 1'b0,1'b1, 3'd4,1'b0,3'd1}, // R3 no retire
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd4,1'b0,3'd1}, // R3
    '{2'd0,3'd0,4'd0, 1'b1,1'b0, 3'd0,1'b1,3'd0}  // R3 expiry
  };

  function automatic logic [30:0] ent_at(int i, logic [2:0] p, logic [3:0] l);
    return 31'({p, l}) << (7 * i);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] c, logic [2:0] p, logic [3:0] l, logic r, logic b,
                      logic w = 1'b0, logic [30:0] d = '0);
    @(negedge clk);
    cmd = c; pg = p; ln = l; retire = r; branch = b; we = w; wdata = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cmd = 2'd0; pg = '0; ln = '0; retire = 0; branch = 0; we = 0; wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 base", 32'(base), 32'd1);
    check("R1 page", 32'(page), 32'd0);
    check("R1 csr", 32'(rdata), 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].c, TBL[i].p, TBL[i].l, TBL[i].r, TBL[i].b);
      check($sformatf("R2-R9 vec %0d page", i), 32'(page), 32'(TBL[i].xp));
      check($sformatf("R2-R9 vec %0d base", i), 32'(base), 32'(TBL[i].xb));
      check($sformatf("R10 vec %0d depth", i), 32'(rdata[30:28]), 32'(TBL[i].xd));
    end

    // R10 layout
    step(2'd1, 3'd3, 4'd5, 1'b1, 1'b0);
    step(2'd1, 3'd6, 4'd15, 1'b1, 1'b0);
    check("R10 csr layout", 32'(rdata),
          32'((31'd2 << 28) | ent_at(1, 3'd6, 4'd15) | ent_at(0, 3'd3, 4'd5)));
    // R12 popped entry cleared
    step(2'd2, 3'd0, 4'd0, 1'b1, 1'b0);
    check("R12 cleared", 32'(rdata), 32'((31'd1 << 28) | ent_at(0, 3'd3, 4'd5)));
    check("R6 page", 32'(page), 32'd3);
    // R8 full stack
    step(2'd1, 3'd1, 4'd1, 1'b0, 1'b0);
    step(2'd1, 3'd2, 4'd2, 1'b0, 1'b0);
    step(2'd1, 3'd4, 4'd3, 1'b0, 1'b0);
    check("R8 depth 4", 32'(rdata[30:28]), 32'd4);
    step(2'd1, 3'd1, 4'd9, 1'b0, 1'b0);
    check("R8 depth held", 32'(rdata[30:28]), 32'd4);
    check("R8 top replaced", 32'(rdata[27:21]), 32'({3'd1, 4'd9}));
    check("R8 below intact", 32'(rdata[20:14]), 32'({3'd2, 4'd2}));
    check("R8 page", 32'(page), 32'd1);
    // R7 from full
    step(2'd3, 3'd0, 4'd0, 1'b0, 1'b0);
    check("R7 csr zero", 32'(rdata), 32'd0);
    // R11 write beats pop
    step(2'd2, 3'd0, 4'd0, 1'b1, 1'b1, 1'b1, (31'd1 << 28) | ent_at(0, 3'd2, 4'd15));
    check("R11 write wins", 32'(rdata), 32'((31'd1 << 28) | ent_at(0, 3'd2, 4'd15)));
    check("R11 page", 32'(page), 32'd2);
    // R11 clamp
    begin
      logic [30:0] d;
      d = 31'd7 << 28;
      for (int k = 0; k < 4; k++) d |= ent_at(k, 3'd5, 4'd15);
      step(2'd0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, d);
      check("R11 clamp depth", 32'(rdata[30:28]), 32'd4);
      check("R11 clamp page", 32'(page), 32'd5);
    end
    step(2'd0, 3'd0, 4'd0, 1'b0, 1'b0);
    check("R1 base after load", 32'(base), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule